// File: doc/BRIEF.md
# Serial ADC Readout Controller

This block reads one 8-bit sample from a three-wire serial analog-to-digital converter. It drives an active-low chip select and a serial clock that it generates itself, and it shifts in the converter's serial data line. A single-cycle start request in idle begins a conversion. The controller pulls chip select low and waits a setup interval. It then issues one leading clock pulse that carries no data and collects eight result bits, most significant first, on the falling edges of the next eight pulses. On the last falling edge the result appears on the output with a one-cycle valid strobe, and chip select is released in the same cycle.

The high time and the low time of the serial clock are separate parameters, counted in system clock cycles. The high time can therefore be stretched so that the converter settles before each bit is taken. The controller derives its limits from the system clock frequency. It lengthens the low time whenever the requested period would push the serial clock above 400 kHz, and it enforces a setup delay of at least 250 ns after chip select falls. After each conversion, chip select stays high for one full serial clock period before the next conversion can begin.

Top module: `adc_serial_reader`

## Requirements
- R1: While idle, the serial clock is low, chip select is high and busy is low.
- R2: A start request sampled in idle pulls chip select low at the next clock edge and raises busy. The first serial clock rise follows after exactly the effective setup count of system cycles. That count is the larger of the setup parameter and ceil(250 ns × clock frequency), and never less than 1.
- R3: Every serial clock pulse stays high for exactly the effective high count, which is the high-time parameter, raised to 1 if it is zero.
- R4: Between pulses the serial clock stays low for the effective low count. That count is the low-time parameter (raised to 1 if zero), lengthened when necessary so that high plus low is at least ceil(clock frequency / 400 kHz) cycles.
- R5: Each conversion issues exactly 9 serial clock pulses while chip select is low. The data line during the first pulse has no effect on the result.
- R6: Result bit 7 is the data line sampled at the falling edge of pulse 2, and bit 0 is the data line sampled at the falling edge of pulse 9.
- R7: The valid strobe lasts exactly one system cycle. It rises together with the last falling edge of the serial clock and the rise of chip select. The result holds its value until the next strobe.
- R8: After chip select rises it stays high for at least high plus low effective cycles. Busy stays high through that interval, and start requests while busy launch no conversion.
- R9: Reset leaves the result at zero and the valid strobe low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Conversion request, sampled while idle |
| adc_sdata | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low chip select to the converter |
| adc_sclk | output | 1 | Generated serial clock |
| busy | output | 1 | High from an accepted start through the recovery interval |
| result_valid | output | 1 | One-cycle strobe marking a new result |
| result | output | DATA_W | Last converted sample, MSB first on the wire |

## Verification
Two events share one cycle here. The capture of the final bit, together with the valid strobe, lands on the same edge as the release of chip select and the end of the last clock pulse. A start request can also arrive while the sequencer is running or recovering. The bench provokes the first case on every conversion of a sweep over all 256 codes. It checks that the result, the strobe and the released chip select are all present together, and that the line timing monitor sees exactly nine pulses. It provokes the second case by holding start high through a whole conversion and its recovery gap, then confirms that chip select never falls again and that the result is unchanged.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        RD_IDLE,
        RD_SETUP,
        RD_HIGH,
        RD_LOW,
        RD_GAP
    } rd_state_e;

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word_nxt
);

    logic [W-2:0] sh_d, sh_q;

    assign word_nxt = {sh_q, din};

    always_comb begin
        sh_d = sh_q;
        if (en) begin
            sh_d = word_nxt[W-2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else begin
            sh_q <= sh_d;
        end
    end

endmodule

// File: rtl/adc_serial_reader.sv
module adc_serial_reader
    import adc_rd_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int MAX_SCLK_HZ = 400_000,
    parameter int SETUP_NS    = 250,
    parameter int SCLK_HI_CYC = 63,
    parameter int SCLK_LO_CYC = 63,
    parameter int SETUP_CYC   = 1,
    parameter int DATA_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              adc_sdata,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic              busy,
    output logic              result_valid,
    output logic [DATA_W-1:0] result
);

    localparam int MIN_PER  = (CLK_HZ + MAX_SCLK_HZ - 1) / MAX_SCLK_HZ;
    localparam int HI_EFF   = max2(SCLK_HI_CYC, 1);
    localparam int LO_REQ   = max2(SCLK_LO_CYC, 1);
    localparam int LO_EFF   = (HI_EFF + LO_REQ < MIN_PER) ? (MIN_PER - HI_EFF) : LO_REQ;
    localparam int SU_RAW   = ((CLK_HZ / 1000) * SETUP_NS + 999_999) / 1_000_000;
    localparam int SU_EFF   = max2(SETUP_CYC, max2(SU_RAW, 1));
    localparam int GAP_EFF  = HI_EFF + LO_EFF;
    localparam int MAX_LD   = max2(max2(HI_EFF, LO_EFF), max2(SU_EFF, GAP_EFF));
    localparam int TW       = $clog2(MAX_LD + 1);
    localparam int SW       = $clog2(DATA_W + 2);
    localparam int NPULSE   = DATA_W + 1;

    typedef struct packed {
        rd_state_e         state;
        logic              sclk;
        logic              cs_n;
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [SW-1:0]     slot;
    } regs_t;

    regs_t r_d, r_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_done;
    logic          sh_en;
    logic [DATA_W-1:0] word_nxt;

    adc_rd_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    adc_rd_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (sh_en),
        .din      (adc_sdata),
        .word_nxt (word_nxt)
    );

    always_comb begin
        r_d      = r_q;
        r_d.valid = 1'b0;
        tmr_load = 1'b0;
        tmr_val  = '0;
        sh_en    = 1'b0;
        unique case (r_q.state)
            RD_IDLE: begin
                if (start) begin
                    r_d.state = RD_SETUP;
                    r_d.cs_n  = 1'b0;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(SU_EFF - 1);
                end
            end
            RD_SETUP: begin
                if (tmr_done) begin
                    r_d.state = RD_HIGH;
                    r_d.sclk  = 1'b1;
                    r_d.slot  = '0;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(HI_EFF - 1);
                end
            end
            RD_HIGH: begin
                if (tmr_done) begin
                    r_d.sclk = 1'b0;
                    sh_en    = (r_q.slot != '0);
                    tmr_load = 1'b1;
                    if (r_q.slot == SW'(DATA_W)) begin
                        r_d.state = RD_GAP;
                        r_d.valid = 1'b1;
                        r_d.data  = word_nxt;
                        r_d.cs_n  = 1'b1;
                        tmr_val   = TW'(GAP_EFF - 1);
                    end else begin
                        r_d.state = RD_LOW;
                        r_d.slot  = r_q.slot + 1'b1;
                        tmr_val   = TW'(LO_EFF - 1);
                    end
                end
            end
            RD_LOW: begin
                if (tmr_done) begin
                    r_d.state = RD_HIGH;
                    r_d.sclk  = 1'b1;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(HI_EFF - 1);
                end
            end
            RD_GAP: begin
                if (tmr_done) begin
                    r_d.state = RD_IDLE;
                end
            end
            default: r_d.state = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: RD_IDLE, sclk: 1'b0, cs_n: 1'b1, valid: 1'b0,
                     data: '0, slot: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign adc_cs_n     = r_q.cs_n;
    assign adc_sclk     = r_q.sclk;
    assign busy         = (r_q.state != RD_IDLE);
    assign result_valid = r_q.valid;
    assign result       = r_q.data;

    // Line-timing observers used only by the assertions below.
    logic [15:0] hi_run_q, lo_run_q, csh_run_q;
    logic [7:0]  pulse_q;
    logic        sclk_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_run_q    <= '0;
            lo_run_q    <= '0;
            csh_run_q   <= '1;
            pulse_q     <= '0;
            sclk_prev_q <= 1'b0;
        end else begin
            sclk_prev_q <= adc_sclk;
            hi_run_q    <= adc_sclk ? hi_run_q + 16'd1 : 16'd0;
            lo_run_q    <= (!adc_cs_n && !adc_sclk) ? lo_run_q + 16'd1 : 16'd0;
            csh_run_q   <= !adc_cs_n ? 16'd0 : (csh_run_q + {15'd0, (csh_run_q != '1)});
            pulse_q     <= adc_cs_n ? 8'd0 : pulse_q + {7'd0, (adc_sclk && !sclk_prev_q)};
        end
    end

    a_r1_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!adc_sclk && adc_cs_n));

    a_r1_sclk_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        adc_sclk |-> !adc_cs_n);

    a_r2_setup_time: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_sclk) && pulse_q == 8'd0) |-> (lo_run_q == 16'(SU_EFF)));

    a_r3_high_time: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sclk) |-> (hi_run_q == 16'(HI_EFF)));

    a_r4_low_time: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(adc_sclk) && pulse_q != 8'd0) |-> (lo_run_q == 16'(LO_EFF)));

    a_r5_nine_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(adc_cs_n) |-> (pulse_q == 8'(NPULSE)));

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    a_r7_strobe_release: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(result_valid) |-> ($rose(adc_cs_n) && $fell(adc_sclk)));

    a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    a_r8_recovery_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (csh_run_q >= 16'(GAP_EFF)));

    a_r8_start_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> ($past(start) && !$past(busy)));

endmodule

// File: tb/tb_adc_serial_reader.sv
module tb_adc_model (
    input  logic       sclk,
    input  logic       cs_n,
    input  logic [7:0] value,
    output logic       sdata
);
    int idx;
    initial begin
        idx   = 0;
        sdata = 1'b0;
    end
    // Pulse 1 carries a deliberately wrong bit; pulses 2..9 carry bits 7..0.
    always @(posedge sclk or posedge cs_n) begin
        if (cs_n) begin
            idx   <= 0;
            sdata <= 1'b0;
        end else begin
            idx <= idx + 1;
            if (idx == 0)      sdata <= ~value[7];
            else if (idx <= 8) sdata <= value[8-idx];
            else               sdata <= 1'b0;
        end
    end
endmodule

module tb_line_monitor #(
    parameter int HI  = 1,
    parameter int LO  = 1,
    parameter int SU  = 1,
    parameter int GAP = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    output int   n_chk,
    output int   n_fail
);
    int hi_run, lo_run, csh, np;
    logic prev_sclk, prev_cs;

    task automatic mchk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s line timing: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        n_chk = 0; n_fail = 0;
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            hi_run = 0; lo_run = 0; csh = 1000; np = 0;
            prev_sclk = 1'b0; prev_cs = 1'b1;
        end else begin
            if (sclk) begin
                if (!prev_sclk) begin
                    if (np == 0) mchk(lo_run == SU, "R2", lo_run, SU);
                    else         mchk(lo_run == LO, "R4", lo_run, LO);
                    np++;
                end
                hi_run++;
                lo_run = 0;
            end else begin
                if (prev_sclk) begin
                    mchk(hi_run == HI, "R3", hi_run, HI);
                    hi_run = 0;
                end
                if (!cs_n) lo_run++;
            end
            if (!cs_n && prev_cs) mchk(csh >= GAP, "R8", csh, GAP);
            if (cs_n && !prev_cs) begin
                mchk(np == 9, "R5", np, 9);
                np = 0;
            end
            if (cs_n) begin
                csh++;
                lo_run = 0;
            end else begin
                csh = 0;
            end
            prev_sclk = sclk;
            prev_cs   = cs_n;
        end
    end
endmodule

module tb_adc_serial_reader;
    localparam int CLK_PERIOD = 10;
    localparam int F_HZ       = 4_000_000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic       start0 = 1'b0, start1 = 1'b0;
    logic       sd0, sd1, cs0, cs1, sck0, sck1, busy0, busy1, val0, val1;
    logic [7:0] res0, res1;
    logic [7:0] mv0 = 8'h00, mv1 = 8'h00;

    int n_vec = 0, n_bad = 0;
    int m0_chk, m0_fail, m1_chk, m1_fail;
    logic [7:0] last0 = 8'h00, last1 = 8'h00;

    adc_serial_reader #(.CLK_HZ(F_HZ), .SCLK_HI_CYC(6), .SCLK_LO_CYC(4), .SETUP_CYC(3)) dut (
        .clk(clk), .rst_n(rst_n), .start(start0), .adc_sdata(sd0), .adc_cs_n(cs0),
        .adc_sclk(sck0), .busy(busy0), .result_valid(val0), .result(res0));

    adc_serial_reader #(.CLK_HZ(F_HZ), .SCLK_HI_CYC(2), .SCLK_LO_CYC(1), .SETUP_CYC(0)) dut_clamp (
        .clk(clk), .rst_n(rst_n), .start(start1), .adc_sdata(sd1), .adc_cs_n(cs1),
        .adc_sclk(sck1), .busy(busy1), .result_valid(val1), .result(res1));

    tb_adc_model mdl0 (.sclk(sck0), .cs_n(cs0), .value(mv0), .sdata(sd0));
    tb_adc_model mdl1 (.sclk(sck1), .cs_n(cs1), .value(mv1), .sdata(sd1));

    // Expected line timing: 4 MHz -> minimum period 10 cycles, setup minimum 1 cycle.
    tb_line_monitor #(.HI(6), .LO(4), .SU(3), .GAP(10)) mon0 (
        .clk(clk), .rst_n(rst_n), .sclk(sck0), .cs_n(cs0), .n_chk(m0_chk), .n_fail(m0_fail));
    tb_line_monitor #(.HI(2), .LO(8), .SU(1), .GAP(10)) mon1 (
        .clk(clk), .rst_n(rst_n), .sclk(sck1), .cs_n(cs1), .n_chk(m1_chk), .n_fail(m1_fail));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==",
                 n_vec + m0_chk + m1_chk, n_bad + m0_fail + m1_fail);
        $finish;
    endtask

    task automatic convert(input bit sel, input logic [7:0] v);
        int w;
        if (sel) mv1 = v; else mv0 = v;
        while (sel ? busy1 : busy0) @(negedge clk);
        chk((sel ? res1 : res0) == (sel ? last1 : last0), "R7 hold", sel ? res1 : res0, sel ? last1 : last0);
        chk((sel ? (sck1 == 1'b0 && cs1 == 1'b1) : (sck0 == 1'b0 && cs0 == 1'b1)), "R1 idle lines", 0, 0);
        if (sel) start1 = 1'b1; else start0 = 1'b1;
        @(negedge clk);
        start1 = 1'b0; start0 = 1'b0;
        chk((sel ? (busy1 && !cs1) : (busy0 && !cs0)), "R2 accept", 0, 0);
        w = 0;
        while (!(sel ? val1 : val0) && w < 2000) begin
            @(negedge clk);
            w++;
        end
        chk((sel ? val1 : val0), "R7 strobe seen", 0, 1);
        chk((sel ? res1 : res0) == v, "R6 result", sel ? res1 : res0, v);
        chk((sel ? (cs1 && !sck1) : (cs0 && !sck0)), "R7 release with strobe", 0, 0);
        @(negedge clk);
        chk(!(sel ? val1 : val0), "R7 single cycle", 1, 0);
        chk((sel ? busy1 : busy0), "R8 busy in gap", 0, 1);
        if (sel) last1 = v; else last0 = v;
    endtask

    initial begin : watchdog
        repeat (150_000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : main
        int falls;
        repeat (3) @(negedge clk);
        // R9 / R1: reset state
        chk(res0 == 8'h00 && !val0, "R9 reset result", res0, 0);
        chk(cs0 && !sck0 && !busy0, "R1 reset lines", 0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(res1 == 8'h00 && !val1 && cs1 && !sck1 && !busy1, "R9 reset clamp instance", res1, 0);

        // R5 / R6: every code; dummy pulse carries an inverted MSB
        for (int v = 0; v < 256; v++) convert(1'b0, 8'(v));
        // R4: clamped instance, low time stretched from 1 to 8
        for (int v = 0; v < 16; v++) convert(1'b1, 8'(v * 17));

        // R8: start held high through a whole conversion and its gap
        while (busy0) @(negedge clk);
        mv0 = 8'hA5;
        start0 = 1'b1;
        @(negedge clk);
        while (!val0) @(negedge clk);
        chk(res0 == 8'hA5, "R6 result under held start", res0, 8'hA5);
        falls = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (!cs0) falls++;
        end
        start0 = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (!cs0) falls++;
        end
        chk(falls == 0, "R8 start ignored while busy", falls, 0);
        chk(res0 == 8'hA5 && !busy0, "R8 no extra conversion", res0, 8'hA5);
        last0 = 8'hA5;
        convert(1'b0, 8'h3C);

        repeat (5) @(negedge clk);
        finish_run();
    end
endmodule